// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C target that holds a small bank of sensor registers behind an index register (the pointer). A bus master writes the target address and then one index byte to pick a register; any further bytes in the same write go into the picked register. A read with no index byte returns data from whichever register was picked last, because the index stays where it was put. To read a different register, the master writes the index, issues a repeated START and then the read address.

Five registers can be picked. The temperature word comes in on a parallel input and cannot be written. The configuration byte is one byte long. The low, high and critical limit words are each two bytes long and are sent and received most significant byte first. SCL and SDA arrive as separate input lines and SDA is driven through an active-high pull-low enable. Both lines pass through a two-flop synchroniser. START and STOP are found from SDA edges while SCL is high. A one-cycle strobe marks each accepted read address so that alarm logic can clear its state.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset the index selects the temperature word (code 0), the configuration byte and all limit words read zero, SDA is released and the read strobe is low.
- R2: Only an address byte whose upper seven bits equal `DEV_ADDR` is acknowledged. After any other address the target leaves SDA released, acknowledges no byte and changes no register until the next START.
- R3: In a write, the first byte after the address loads the index from its low three bits (0 temperature, 1 configuration, 2 low limit, 3 high limit, 4 critical limit). The target acknowledges every byte of a write addressed to it.
- R4: A write to the configuration byte takes effect with the first data byte. A limit word takes the first data byte as its upper half and is updated when its second data byte arrives. A write that stops after the upper half leaves the word unchanged. Data bytes after the register's length are acknowledged and discarded.
- R5: Writes to the temperature word (code 0) and to codes 5 to 7 are acknowledged and have no effect. Codes 5 to 7 read as 0x00.
- R6: A read that is not preceded by an index write returns the register picked by the most recent index write. The index is kept across transactions.
- R7: Read data is shifted out most significant bit first, and a two-byte word is sent upper byte first. After each byte the master acknowledges, the target sends the next byte: a two-byte word alternates between its upper and lower byte, and the configuration byte repeats. The target changes SDA only while SCL is low.
- R8: An index write followed by a repeated START and a matching read address returns data from the newly written index.
- R9: After the last read byte the target accepts either a master NACK, which releases the bus, or a master ACK followed by a STOP. A STOP always returns the target to idle with SDA released.
- R10: If the master ends a read after only the upper byte of a word, the target may hold SDA low. It releases SDA within nine further SCL clocks, and a STOP then leaves it ready for a normal transaction.
- R11: `rdStrobe` pulses high for one clock at the acknowledge of a matching read address, and never for a write or a non-matching address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level as seen on the bus |
| sdaIn | input | 1 | SDA level as seen on the bus |
| sdaOe | output | 1 | High to pull SDA low |
| tempIn | input | 16 | Current temperature word, read only |
| cfgOut | output | 8 | Configuration byte |
| lowOut | output | 16 | Low limit word |
| highOut | output | 16 | High limit word |
| critOut | output | 16 | Critical limit word |
| rdStrobe | output | 1 | One-cycle pulse for each accepted read address |

## Verification
If the bit counter or the state register goes wrong, the master sees it at the next acknowledge slot: the ACK goes missing or appears in the wrong place, or SDA stays low, within one byte time of the fault. If the index or the write staging goes wrong, no bus event shows it. It appears on the parallel register outputs one system clock after the completing byte, or in the first byte of the next read. For that reason the bench compares every byte it reads against a queue of expected values and samples the register ports after each write.

// File: rtl/ipt_pkg.sv
`timescale 1ns/1ps
package ipt_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int PTR_W    = 3;
  localparam int NUM_LIM  = 3;
  localparam int LIM_BASE = 2;

  typedef enum logic [PTR_W-1:0] {
    SEL_TEMP = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_LOW  = 3'd2,
    SEL_HIGH = 3'd3,
    SEL_CRIT = 3'd4
  } sel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_st_e;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic rxShift;
    logic ptrLoad;
    logic wrFirst;
    logic wrSecond;
    logic txLoad;
    logic txIdx;
    logic txShift;
  } strobe_t;
endpackage

// File: rtl/ipt_sync.sv
`timescale 1ns/1ps
module ipt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclPipe[STAGES-1];
      sdaD    <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/ipt_ctrl.sv
`timescale 1ns/1ps
module ipt_ctrl
  import ipt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  input  logic              wideSel,
  output strobe_t           stb,
  output logic              sdaOe,
  output logic              rdStrobe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  bus_st_e          state;
  logic [CNT_W-1:0] bitCnt;
  logic [1:0]       dataCnt;
  logic             rwBit, mAck, rdIdx;
  logic             byteDone, addrHit, nextIdx;

  assign byteDone = (bitCnt == LAST);
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign nextIdx  = wideSel & ~rdIdx;

  always_comb begin
    stb          = '0;
    stb.rxShift  = sclRise && !byteDone && (state == ST_ADDR || state == ST_WR);
    stb.ptrLoad  = sclFall && byteDone && state == ST_WR && dataCnt == 2'd0;
    stb.wrFirst  = sclFall && byteDone && state == ST_WR && dataCnt == 2'd1;
    stb.wrSecond = sclFall && byteDone && state == ST_WR && dataCnt == 2'd2;
    stb.txLoad   = sclFall && ((state == ST_ADDR_ACK && rwBit) ||
                               (state == ST_RD_ACK && mAck));
    stb.txIdx    = (state == ST_RD_ACK) ? nextIdx : 1'b0;
    stb.txShift  = sclFall && !byteDone && state == ST_RD;
  end

  assign sdaOe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 (state == ST_RD && !txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      dataCnt <= '0;
      rwBit   <= 1'b0;
      mAck    <= 1'b0;
      rdIdx   <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (startDet) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else begin
      if (stb.txLoad) rdIdx <= stb.txIdx;
      case (state)
        ST_ADDR: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + CNT_W'(1);
          else if (sclFall && byteDone) begin
            bitCnt <= '0;
            if (addrHit) begin
              state <= ST_ADDR_ACK;
              rwBit <= rxByte[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            state   <= rwBit ? ST_RD : ST_WR;
            dataCnt <= '0;
          end
        end
        ST_WR: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + CNT_W'(1);
          else if (sclFall && byteDone) begin
            bitCnt <= '0;
            state  <= ST_WR_ACK;
            if (dataCnt != 2'd3) dataCnt <= dataCnt + 2'd1;
          end
        end
        ST_WR_ACK: if (sclFall) state <= ST_WR;
        ST_RD: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + CNT_W'(1);
          else if (sclFall && byteDone) begin
            bitCnt <= '0;
            state  <= ST_RD_ACK;
          end
        end
        ST_RD_ACK: begin
          if (sclRise) mAck <= ~sdaS;
          if (sclFall) state <= mAck ? ST_RD : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdStrobe <= 1'b0;
    else rdStrobe <= !stopDet && !startDet && state == ST_ADDR && sclFall &&
                     byteDone && addrHit && rxByte[0];
  end

  // R7
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !sdaOe));
  // R11
  strobe_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> (state == ST_ADDR_ACK && rwBit && sdaOe));
  // R10
  bit_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST);
endmodule

// File: rtl/ipt_dp.sv
`timescale 1ns/1ps
module ipt_dp
  import ipt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            sdaS,
  input  strobe_t                         stb,
  input  logic [WORD_W-1:0]               tempIn,
  output logic [BYTE_W-1:0]               rxByte,
  output logic                            txMsb,
  output logic                            wideSel,
  output logic [BYTE_W-1:0]               cfgOut,
  output logic [NUM_LIM-1:0][WORD_W-1:0]  limOut
);
  localparam int LIM_IW = $clog2(NUM_LIM);

  logic [BYTE_W-1:0] rxSh, txSh, stage, cfgReg;
  logic [PTR_W-1:0]  ptr;
  logic [WORD_W-1:0] limReg [NUM_LIM];
  logic [WORD_W-1:0] selWord;
  logic [LIM_IW-1:0] limOff;
  logic              limHit;

  assign limOff = LIM_IW'(ptr - PTR_W'(LIM_BASE));
  assign limHit = (32'(ptr) >= LIM_BASE) && (32'(ptr) < LIM_BASE + NUM_LIM);

  always_comb begin
    selWord = '0;
    wideSel = 1'b0;
    if (ptr == PTR_W'(SEL_TEMP)) begin
      selWord = tempIn;
      wideSel = 1'b1;
    end else if (ptr == PTR_W'(SEL_CFG)) begin
      selWord = {cfgReg, {BYTE_W{1'b0}}};
    end else if (limHit) begin
      selWord = limReg[limOff];
      wideSel = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh   <= '0;
      txSh   <= '0;
      stage  <= '0;
      cfgReg <= '0;
      ptr    <= PTR_W'(SEL_TEMP);
      for (int i = 0; i < NUM_LIM; i++) limReg[i] <= '0;
    end else begin
      if (stb.rxShift) rxSh <= {rxSh[BYTE_W-2:0], sdaS};
      if (stb.ptrLoad) ptr <= rxSh[PTR_W-1:0];
      if (stb.wrFirst) stage <= rxSh;
      if (stb.wrFirst && ptr == PTR_W'(SEL_CFG)) cfgReg <= rxSh;
      for (int i = 0; i < NUM_LIM; i++)
        if (stb.wrSecond && 32'(ptr) == LIM_BASE + i) limReg[i] <= {stage, rxSh};
      if (stb.txLoad)
        txSh <= stb.txIdx ? selWord[BYTE_W-1:0] : selWord[WORD_W-1:BYTE_W];
      else if (stb.txShift)
        txSh <= {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  assign rxByte = rxSh;
  assign txMsb  = txSh[BYTE_W-1];
  assign cfgOut = cfgReg;

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_limOut
    assign limOut[g] = limReg[g];
  end

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ptr) |-> $past(stb.ptrLoad));
  // R4
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgReg) |-> ($past(stb.wrFirst) && $past(ptr) == PTR_W'(SEL_CFG)));
endmodule

// File: rtl/i2c_ptr_target.sv
`timescale 1ns/1ps
module i2c_ptr_target
  import ipt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  input  logic [15:0] tempIn,
  output logic [7:0]  cfgOut,
  output logic [15:0] lowOut,
  output logic [15:0] highOut,
  output logic [15:0] critOut,
  output logic        rdStrobe
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txMsb, wideSel;
  strobe_t stb;
  logic [NUM_LIM-1:0][WORD_W-1:0] limOut;

  ipt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  ipt_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txMsb(txMsb), .wideSel(wideSel),
    .stb(stb), .sdaOe(sdaOe), .rdStrobe(rdStrobe)
  );

  ipt_dp u_dp (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .stb(stb), .tempIn(tempIn),
    .rxByte(rxByte), .txMsb(txMsb), .wideSel(wideSel),
    .cfgOut(cfgOut), .limOut(limOut)
  );

  assign lowOut  = limOut[0];
  assign highOut = limOut[1];
  assign critOut = limOut[2];
endmodule

// File: tb/i2c_ptr_target_tb.sv
`timescale 1ns/1ps
module i2c_ptr_target_tb;
  localparam logic [6:0] DEVA = 7'h48;
  localparam int Q = 16;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, sclDrv = 1'b1, mLow = 1'b0;
  logic sdaLine, sdaOe, rdStrobe;
  logic [15:0] tempIn = 16'h1A2B;
  logic [7:0] cfgOut;
  logic [15:0] lowOut, highOut, critOut;

  assign sdaLine = !(mLow || sdaOe);

  i2c_ptr_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .tempIn(tempIn), .cfgOut(cfgOut), .lowOut(lowOut), .highOut(highOut),
    .critOut(critOut), .rdStrobe(rdStrobe)
  );

  int nChk = 0, nErr = 0, strbCnt = 0, expStrb = 0;
  bit done = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t expQ[$];
  logic [7:0] obsQ[$];
  event obsEv;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops observed bytes and compares with the scoreboard queue
  initial forever begin
    @(obsEv);
    while (obsQ.size() > 0) begin
      logic [7:0] o;
      exp_t e;
      o = obsQ.pop_front();
      if (expQ.size() == 0) begin
        nChk++; nErr++;
        $display("FAIL R7: actual=%0h expected=none", o);
      end else begin
        e = expQ.pop_front();
        check(e.tag, 32'(o), 32'(e.val));
      end
    end
  end

  always @(negedge clk) if (rdStrobe) strbCnt++;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    mLow = 1'b0; waitClk(H); sclDrv = 1'b1; waitClk(Q);
    mLow = 1'b1; waitClk(Q); sclDrv = 1'b0; waitClk(H);
  endtask

  task automatic stopC();
    mLow = 1'b1; waitClk(H); sclDrv = 1'b1; waitClk(Q);
    mLow = 1'b0; waitClk(Q);
  endtask

  task automatic sendBit(input logic b);
    mLow = !b; waitClk(H); sclDrv = 1'b1; waitClk(Q); sclDrv = 1'b0; waitClk(H);
  endtask

  task automatic recvBit(output logic b);
    mLow = 1'b0; waitClk(H); sclDrv = 1'b1; waitClk(Q/2);
    b = sdaLine; waitClk(Q/2); sclDrv = 1'b0; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = !b;
  endtask

  task automatic recvByte(input logic giveAck);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin recvBit(b); d[i] = b; end
    sendBit(!giveAck);
    obsQ.push_back(d);
    -> obsEv;
  endtask

  task automatic expectByte(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic wrTxn(input logic [7:0] ptrB, input int n, input logic [23:0] dat, input string tag);
    logic a;
    startC();
    sendByte({DEVA, 1'b0}, a); check(tag, 32'(a), 1);
    sendByte(ptrB, a);         check(tag, 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      sendByte(dat[23-8*k -: 8], a); check(tag, 32'(a), 1);
    end
    stopC();
  endtask

  task automatic readPart(input int n, input logic [23:0] ev, input logic lastAck, input string tag);
    logic a;
    sendByte({DEVA, 1'b1}, a); check(tag, 32'(a), 1);
    expStrb++;
    for (int k = 0; k < n; k++) begin
      expectByte(ev[23-8*k -: 8], tag);
      recvByte((k < n-1) ? 1'b1 : lastAck);
    end
  endtask

  task automatic rdTxn(input int n, input logic [23:0] ev, input logic lastAck, input string tag);
    startC(); readPart(n, ev, lastAck, tag); stopC();
  endtask

  task automatic ptrRdTxn(input logic [7:0] ptrB, input int n, input logic [23:0] ev,
                          input logic lastAck, input string tag);
    logic a;
    startC();
    sendByte({DEVA, 1'b0}, a); check(tag, 32'(a), 1);
    sendByte(ptrB, a);         check(tag, 32'(a), 1);
    startC();
    readPart(n, ev, lastAck, tag);
    stopC();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nErr++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    logic a, b;
    waitClk(5); rstN = 1'b1; waitClk(4);
    // R1 reset state
    check("R1 sdaOe", 32'(sdaOe), 0);
    check("R1 cfgOut", 32'(cfgOut), 0);
    check("R1 lowOut", 32'(lowOut), 0);
    check("R1 highOut", 32'(highOut), 0);
    check("R1 critOut", 32'(critOut), 0);
    check("R1 rdStrobe", 32'(rdStrobe), 0);

    // R1 R6 R7: plain read starts at temperature
    rdTxn(2, 24'h1A2B00, 1'b0, "R1 R6 R7 temp read");
    check("R11 strobe count", 32'(strbCnt), 32'(expStrb));

    // R2 foreign address
    startC();
    sendByte({7'h49, 1'b0}, a); check("R2 foreign write nack", 32'(a), 0);
    sendByte(8'h01, a);         check("R2 later byte ignored", 32'(a), 0);
    sendByte(8'hEE, a);
    stopC();
    check("R2 cfg untouched", 32'(cfgOut), 0);
    startC();
    sendByte({7'h49, 1'b1}, a); check("R2 foreign read nack", 32'(a), 0);
    stopC();
    check("R11 no strobe on foreign", 32'(strbCnt), 32'(expStrb));

    // R3 R4 writes
    wrTxn(8'h01, 1, 24'h5C0000, "R3 cfg write ack");
    check("R4 cfg value", 32'(cfgOut), 32'h5C);
    wrTxn(8'h02, 2, 24'h123400, "R3 low write ack");
    check("R4 low value", 32'(lowOut), 32'h1234);
    wrTxn(8'h03, 1, 24'h770000, "R4 partial ack");
    check("R4 partial keeps high", 32'(highOut), 0);
    wrTxn(8'h03, 3, 24'hABCDEE, "R4 extra byte ack");
    check("R4 high value", 32'(highOut), 32'hABCD);
    check("R4 extra byte no effect low", 32'(lowOut), 32'h1234);
    check("R4 extra byte no effect cfg", 32'(cfgOut), 32'h5C);
    wrTxn(8'h04, 2, 24'h0F8000, "R3 crit write ack");
    check("R4 crit value", 32'(critOut), 32'h0F80);
    check("R11 no strobe on write", 32'(strbCnt), 32'(expStrb));

    // R5 read-only and unused codes
    wrTxn(8'h00, 2, 24'h999900, "R5 temp write ack");
    rdTxn(2, 24'h1A2B00, 1'b0, "R5 temp unchanged");
    wrTxn(8'hFE, 2, 24'h556600, "R5 unused code write ack");
    check("R5 low kept", 32'(lowOut), 32'h1234);
    check("R5 high kept", 32'(highOut), 32'hABCD);
    check("R5 crit kept", 32'(critOut), 32'h0F80);
    check("R5 cfg kept", 32'(cfgOut), 32'h5C);
    rdTxn(1, 24'h000000, 1'b0, "R5 unused code reads zero");

    // R6 sticky index
    wrTxn(8'h02, 0, 24'h0, "R3 index only");
    rdTxn(2, 24'h123400, 1'b0, "R6 sticky first");
    rdTxn(2, 24'h123400, 1'b0, "R6 sticky second");
    check("R11 strobe per read", 32'(strbCnt), 32'(expStrb));

    // R8 repeated start, R7 config repeats and word wraps
    ptrRdTxn(8'h01, 2, 24'h5C5C00, 1'b0, "R8 R7 cfg repeat");
    ptrRdTxn(8'h04, 3, 24'h0F800F, 1'b0, "R8 R7 word wrap");

    // R9 ACK on last byte then STOP
    tempIn = 16'h9A2B;
    ptrRdTxn(8'h00, 2, 24'h9A2B00, 1'b1, "R9 ack then stop");
    check("R9 released after stop", 32'(sdaOe), 0);
    rdTxn(1, 24'h9A0000, 1'b0, "R9 next read after stop");

    // R10 recovery from a one-byte read of a word
    startC();
    sendByte({DEVA, 1'b0}, a); check("R10 addr ack", 32'(a), 1);
    sendByte(8'h02, a);        check("R10 index ack", 32'(a), 1);
    startC();
    readPart(1, 24'h120000, 1'b1, "R10 upper byte");
    check("R10 sda held low", 32'(sdaLine), 0);
    for (int k = 0; k < 9; k++) recvBit(b);
    check("R10 sda released", 32'(sdaLine), 1);
    check("R10 oe released", 32'(sdaOe), 0);
    stopC();
    rdTxn(2, 24'h123400, 1'b0, "R10 bus usable again");
    check("R11 final strobe count", 32'(strbCnt), 32'(expStrb));

    waitClk(50);
    check("R7 scoreboard drained", 32'(expQ.size()), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule